// File: doc/BRIEF.md
# VGA Frame Byte Stream Generator

This block writes one full 640x480 VGA frame as a flat sequence of bytes into a memory. A free-running address counter later plays that memory back straight to the display pins. Each byte holds everything the monitor needs for one pixel clock: an active-low vertical sync bit, an active-low horizontal sync bit and a 6-bit colour, with two bits each for red, green and blue. Since the memory carries the timing itself, playback needs no timing logic.

A `start` pulse begins a frame at address zero. For every byte the block raises a write strobe together with the address and the data, and the address rises by one per byte. Porch and sync bytes come from internal counters and never stall. In the visible pixel slots the block asks for colours through a valid/ready handshake and waits while no colour is offered. The frame opens with the vertical back-porch lines. It closes with two filler bytes that have both sync bits high, so that the played-back stream wraps onto the right phase. A one-cycle `done` pulse follows the last byte. All porch, pulse and active lengths are parameters, and the defaults give 525 lines of 800 bytes plus 2.

Top module: `vga_frame_stream`

## Requirements
- R1: Byte layout: bit 7 is vertical sync (active low), bit 6 is horizontal sync (active low), bits 5:4 are red, bits 3:2 are green, bits 1:0 are blue.
- R2: Every line is, in order: H_FRONT bytes with bit 6 high, H_PULSE bytes with bit 6 low, H_BACK bytes with bit 6 high, then H_ACTIVE pixel-slot bytes.
- R3: Any byte whose bit 6 is low has bits 5:0 equal to zero.
- R4: Lines are, in order: V_BACK back-porch lines, V_ACTIVE visible lines, V_FRONT front-porch lines, then V_PULSE sync lines. Bit 7 is low in the sync lines and only there, and no colour is requested while bit 7 is low.
- R5: In every line other than a visible line, all bytes have bits 5:0 equal to zero.
- R6: After the last sync line, TAIL_BYTES bytes of value 0xC0 are written.
- R7: A pixel-slot byte in a visible line is {1,1,pix_rgb}, taken from the handshake. `pix_ready` is high only in such slots, and one colour is consumed per slot, in order.
- R8: When `pix_ready` is high and `pix_valid` is low, no byte is written and the address holds.
- R9: The first byte of a frame goes to address 0, and each write goes to the previous address plus one. A frame writes exactly (H total)x(V total)+TAIL_BYTES bytes.
- R10: `done` is high for exactly one cycle, in the cycle after the final byte, with `busy` already low.
- R11: `start` while busy has no effect on the stream. `start` while idle begins a new frame at address 0.
- R12: After reset and while idle: `busy`, `done`, `wr_en` and `pix_ready` are low, whatever `pix_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame when idle |
| pix_valid | input | 1 | A colour is offered on pix_rgb |
| pix_rgb | input | 6 | Colour {r[1:0],g[1:0],b[1:0]} |
| pix_ready | output | 1 | The current byte is a visible pixel slot |
| wr_en | output | 1 | Write strobe for wr_addr/wr_data |
| wr_addr | output | ADDR_W | Byte address, 19 bits at defaults |
| wr_data | output | 8 | Encoded frame byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
A wrong horizontal or vertical segment state shows up in the very byte where it happens. The sync bit, the zero colour field or the pixel value disagrees with what the byte's address predicts. The bench compares every written byte against a model indexed by address, and runs the frame once without stalls and once with a gapped colour source. A miscounted frame length or tail appears as a byte count off by one and a `done` pulse at the wrong cycle. A broken stall shows up as a write while `pix_valid` is low.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

    // Order of the four horizontal segments in a line
    localparam logic [1:0] HS_FRONT  = 2'd0;
    localparam logic [1:0] HS_PULSE  = 2'd1;
    localparam logic [1:0] HS_BACK   = 2'd2;
    localparam logic [1:0] HS_ACTIVE = 2'd3;

    // Order of the four vertical segments in a frame
    localparam logic [1:0] VS_BACK   = 2'd0;
    localparam logic [1:0] VS_ACTIVE = 2'd1;
    localparam logic [1:0] VS_FRONT  = 2'd2;
    localparam logic [1:0] VS_PULSE  = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LINES = 2'd1,
        PH_TAIL  = 2'd2
    } phase_e;

    // Bit 7 down to bit 0, as decoded by the playback side
    typedef struct packed {
        logic       vsync_n;
        logic       hsync_n;
        logic [1:0] red;
        logic [1:0] green;
        logic [1:0] blue;
    } frame_byte_t;

endpackage

// File: rtl/vfg_seg_counter.sv
module vfg_seg_counter #(
    parameter int unsigned LEN0 = 1,
    parameter int unsigned LEN1 = 1,
    parameter int unsigned LEN2 = 1,
    parameter int unsigned LEN3 = 1,
    localparam int unsigned M01  = (LEN0 > LEN1) ? LEN0 : LEN1,
    localparam int unsigned M23  = (LEN2 > LEN3) ? LEN2 : LEN3,
    localparam int unsigned MAXL = (M01 > M23) ? M01 : M23,
    localparam int unsigned CW   = $clog2(MAXL + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       adv,
    output logic [1:0] seg,
    output logic       wrap
);

    typedef struct packed {
        logic [1:0]    seg;
        logic [CW-1:0] cnt;
    } seg_state_t;

    seg_state_t    st_d, st_q;
    logic [CW-1:0] seg_len;
    logic          at_end;

    always_comb begin
        unique case (st_q.seg)
            2'd0:    seg_len = CW'(LEN0);
            2'd1:    seg_len = CW'(LEN1);
            2'd2:    seg_len = CW'(LEN2);
            default: seg_len = CW'(LEN3);
        endcase
        at_end = (st_q.cnt == seg_len - CW'(1));
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (adv) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.seg = st_q.seg + 2'd1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg  = st_q.seg;
    assign wrap = adv && at_end && (st_q.seg == 2'd3);

    // R2 / R4: position never leaves the current segment's length
    p_seg_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < seg_len);

endmodule

// File: rtl/vfg_byte_pack.sv
module vfg_byte_pack
    import vfg_pkg::*;
(
    input  logic       tail,
    input  logic [1:0] hseg,
    input  logic [1:0] vseg,
    input  logic [5:0] rgb,
    output logic       pixel_slot,
    output logic [7:0] data
);

    frame_byte_t fb;

    always_comb begin
        pixel_slot = !tail && (hseg == HS_ACTIVE) && (vseg == VS_ACTIVE);
        fb         = '0;
        fb.vsync_n = tail || (vseg != VS_PULSE);
        fb.hsync_n = tail || (hseg != HS_PULSE);
        if (pixel_slot) begin
            fb.red   = rgb[5:4];
            fb.green = rgb[3:2];
            fb.blue  = rgb[1:0];
        end
        data = fb;
    end

endmodule

// File: rtl/vga_frame_stream.sv
module vga_frame_stream
    import vfg_pkg::*;
#(
    parameter int unsigned H_FRONT    = 16,
    parameter int unsigned H_PULSE    = 96,
    parameter int unsigned H_BACK     = 48,
    parameter int unsigned H_ACTIVE   = 640,
    parameter int unsigned V_BACK     = 33,
    parameter int unsigned V_ACTIVE   = 480,
    parameter int unsigned V_FRONT    = 10,
    parameter int unsigned V_PULSE    = 2,
    parameter int unsigned TAIL_BYTES = 2,
    localparam int unsigned H_TOTAL = H_FRONT + H_PULSE + H_BACK + H_ACTIVE,
    localparam int unsigned V_TOTAL = V_BACK + V_ACTIVE + V_FRONT + V_PULSE,
    localparam int unsigned TOTAL   = H_TOTAL * V_TOTAL + TAIL_BYTES,
    localparam int unsigned ADDR_W  = $clog2(TOTAL + 1),
    localparam int unsigned TW      = (TAIL_BYTES > 1) ? $clog2(TAIL_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pix_valid,
    input  logic [5:0]        pix_rgb,
    output logic              pix_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [TW-1:0]     tail_cnt;
        logic              done;
    } top_state_t;

    top_state_t st_d, st_q;

    logic       in_lines, in_tail, pixel_slot, fire;
    logic       clear, h_adv, v_adv, h_wrap, v_wrap;
    logic [1:0] hseg, vseg;

    assign in_lines = (st_q.phase == PH_LINES);
    assign in_tail  = (st_q.phase == PH_TAIL);
    assign clear    = (st_q.phase == PH_IDLE) && start;
    assign fire     = in_tail || (in_lines && (!pixel_slot || pix_valid));
    assign h_adv    = in_lines && fire;
    assign v_adv    = h_adv && h_wrap;

    vfg_seg_counter #(
        .LEN0(H_FRONT), .LEN1(H_PULSE), .LEN2(H_BACK), .LEN3(H_ACTIVE)
    ) i_hcnt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .adv(h_adv),
        .seg(hseg), .wrap(h_wrap)
    );

    vfg_seg_counter #(
        .LEN0(V_BACK), .LEN1(V_ACTIVE), .LEN2(V_FRONT), .LEN3(V_PULSE)
    ) i_vcnt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .adv(v_adv),
        .seg(vseg), .wrap(v_wrap)
    );

    vfg_byte_pack i_pack (
        .tail(in_tail), .hseg(hseg), .vseg(vseg), .rgb(pix_rgb),
        .pixel_slot(pixel_slot), .data(wr_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_LINES;
                    st_d.addr  = '0;
                end
            end
            PH_LINES: begin
                if (fire) st_d.addr = st_q.addr + ADDR_W'(1);
                if (v_wrap) begin
                    st_d.tail_cnt = '0;
                    if (TAIL_BYTES == 0) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_TAIL;
                    end
                end
            end
            PH_TAIL: begin
                st_d.addr = st_q.addr + ADDR_W'(1);
                if (int'(st_q.tail_cnt) == int'(TAIL_BYTES) - 1) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.tail_cnt = st_q.tail_cnt + TW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_ready = in_lines && pixel_slot;
    assign wr_en     = fire;
    assign wr_addr   = st_q.addr;
    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;

    // R9: consecutive writes land on consecutive addresses
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    // R8: a missing colour stalls the stream
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |-> !wr_en);

    // R3: horizontal sync bytes carry no colour
    p_sync_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[6]) |-> (wr_data[5:0] == 6'd0));

    // R4: no colour request during vertical sync
    p_vsync_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7]) |-> !pix_ready);

    // R10: done is a single-cycle pulse, seen when idle right after a write
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(wr_en)));

    // R12: idle block neither writes nor requests
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !pix_ready));

endmodule

// File: tb/test_vga_frame_stream.sv
module test_vga_frame_stream;

    localparam int HF = 2, HP = 3, HB = 2, HA = 4;
    localparam int VB = 2, VA = 3, VF = 1, VP = 2;
    localparam int TB = 2;
    localparam int HT = HF + HP + HB + HA;
    localparam int VT = VB + VA + VF + VP;
    localparam int TOT = HT * VT + TB;
    localparam int AW = $clog2(TOT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [5:0]    pix_rgb = '0;
    logic          pix_ready, wr_en, busy, done;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vga_frame_stream #(
        .H_FRONT(HF), .H_PULSE(HP), .H_BACK(HB), .H_ACTIVE(HA),
        .V_BACK(VB), .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VP),
        .TAIL_BYTES(TB)
    ) i_vga_frame_stream (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_ready(pix_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pval(input int k);
        return 6'((k * 5 + 3) & 63);
    endfunction

    // Expected byte at address a, from the requirements
    function automatic logic [7:0] exp_byte(input int a, output string tag);
        int line, col, pbase;
        logic vs, hs, act;
        logic [5:0] rgb;
        if (a >= HT * VT) begin
            tag = "R6";
            return 8'hC0;
        end
        line  = a / HT;
        col   = a % HT;
        pbase = HF + HP + HB;
        vs    = !(line >= VB + VA + VF);
        hs    = !(col >= HF && col < HF + HP);
        act   = (line >= VB) && (line < VB + VA) && (col >= pbase);
        rgb   = act ? pval((line - VB) * HA + col - pbase) : 6'd0;
        if (act)                          tag = "R7 R1";
        else if (!vs)                     tag = "R4";
        else if (!hs)                     tag = "R3";
        else if (line < VB || line >= VB + VA) tag = "R5";
        else                              tag = "R2";
        return {vs, hs, rgb};
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        pix_valid = 1'b1;
        #1;
        check(!busy && !done && !wr_en && !pix_ready, "R12 reset",
              {busy, done, wr_en, pix_ready}, 0);
        repeat (3) @(negedge clk);
        #1;
        check(!wr_en && !pix_ready, "R12 idle valid", {wr_en, pix_ready}, 0);
        pix_valid = 1'b0;
    endtask

    // mode 0: colour always offered; mode 1: gapped source
    task automatic t_frame(input int mode, input bit poke_start);
        int n = 0, pidx = 0, cyc = 0;
        bit last_seen = 0, fin = 0;
        string tag;
        logic [7:0] e;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 5000) begin
            pix_valid = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            pix_rgb   = pval(pidx);
            start     = poke_start && (cyc == 20 || cyc == 21);
            #1;
            if (last_seen) begin
                check(done && !busy, "R10 done after last", {done, busy}, 2);
                fin = 1;
            end else begin
                if (done) check(0, "R10 early done", 1, 0);
                if (pix_ready && !pix_valid)
                    check(!wr_en, "R8 stall", wr_en, 0);
                if (wr_en) begin
                    check(int'(wr_addr) == n, "R9 addr", int'(wr_addr), n);
                    e = exp_byte(n, tag);
                    check(wr_data == e, tag, wr_data, e);
                    n++;
                    if (n == TOT) last_seen = 1;
                end
                if (pix_valid && pix_ready) pidx++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(n == TOT, "R9 byte count", n, TOT);
        check(pidx == VA * HA, "R7 colours consumed", pidx, VA * HA);
        #1;
        check(!done && !busy && !wr_en, "R10 single pulse", {done, busy, wr_en}, 0);
        if (poke_start)
            check(1, "R11 start while busy ignored", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_frame(0, 1'b0);
        t_frame(1, 1'b1);
        t_frame(0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule